// File: doc/BRIEF.md
# Three-Wire Handshake Byte Transfer Engine

This block carries byte packets in both directions between a host processor and a controller through a single shift data register. The host paces every byte with two active-low control lines in a shared control byte: transfer-in-progress (TIP) and acknowledge (TACK). The engine answers on a third active-low line, transfer-request (TREQ). One bit in a mode register picks the direction. No serial clock is involved. Each change of the TIP/TACK pair while TIP is asserted moves exactly one byte.

Bytes sent by the host are collected into a 16-entry outbound buffer. When TIP is released, the collected packet is presented on a valid/length/bytes interface for one cycle. Reply packets of up to 128 bytes are written into a reply store and then committed with a length. They are then handed to the host byte by byte through the shift data register, and TREQ tells the host when a reply is waiting. Every byte step, every end of transfer and every reply commit raises a sticky shift flag. The host clears that flag with a strobe.

Top module: `hsk_xfer_engine`

## Requirements
- R1: After reset the control byte reads 0x38, with bit 5 = TIP, bit 4 = TACK and bit 3 = TREQ, all high and so deasserted. The shift data register reads 0, the shift flag is 0, pkt_valid is 0 and pkt_len is 0.
- R2: A control write (reg_sel 0) stores bits 7:4 and 2:0 as written. Bit 3 (TREQ) belongs to the engine, and the written value of bit 3 has no effect.
- R3: With TIP low and mode bit 4 = 1, a control write that changes the TIP/TACK pair appends the shift data byte to the outbound buffer and sets the shift flag.
- R4: The outbound buffer holds at most 16 bytes. A pair change while it is full stores nothing and leaves the shift flag clear.
- R5: A control write that raises TIP always sets the shift flag. If at least one byte was collected, pkt_valid pulses for one cycle with pkt_len equal to the count and byte k at pkt_bytes[8k+7:8k]. The count then returns to zero.
- R6: With TIP low, mode bit 4 = 0 and reply bytes pending, a TIP/TACK pair change loads the next reply byte into the shift data register and sets the shift flag.
- R7: Loading the last reply byte drives TREQ high.
- R8: With TIP high both before and after a control write, a change of TACK makes TREQ take the new TACK level and sets the shift flag.
- R9: When an update leaves TIP high with no TACK change and reply bytes are pending, TREQ is driven low.
- R10: A commit (rpl_commit with rpl_len, clamped to 128) restarts the reply at byte 0, evaluates the handshake and sets the shift flag. This includes a commit of length 0.
- R11: flag_clr clears the shift flag. If a set and flag_clr fall in the same cycle, the set wins.
- R12: The handshake is evaluated only on control writes, mode writes (reg_sel 1) and commits. A shift data write (reg_sel 2) only replaces the shift data byte.
- R13: When a commit and a control write fall in the same cycle, the handshake evaluates the written control byte against the newly committed packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 control byte, 1 mode, 2 shift data |
| reg_wdata | input | 8 | Register write data |
| flag_clr | input | 1 | Clear the shift flag |
| rpl_wr | input | 1 | Reply store write strobe |
| rpl_waddr | input | 7 | Reply store byte address |
| rpl_wdata | input | 8 | Reply store byte |
| rpl_commit | input | 1 | Start a reply packet |
| rpl_len | input | 8 | Reply packet length in bytes |
| port_b | output | 8 | Control byte including the engine-driven TREQ |
| shift_data | output | 8 | Shift data register |
| sh_flag | output | 1 | Sticky shift flag |
| pkt_valid | output | 1 | One-cycle outbound packet strobe |
| pkt_len | output | 5 | Outbound packet length |
| pkt_bytes | output | 128 | Outbound packet bytes, byte 0 lowest |

## Verification
Two pairs of events can land in one cycle. The first pair is a reply commit and a host control write. The bench issues both in a single cycle, with TIP falling and the receive direction selected. It then expects the first byte of the fresh packet in the shift data register, which shows that the handshake saw the committed packet rather than the old, empty one. The second pair is a flag-setting handshake event and the host's flag clear. The bench drives an idle TACK change together with flag_clr and expects the flag to stay set while TREQ follows TACK.

// File: rtl/hsk_pkg.sv
// Shared constants for the handshake transfer engine.
// Assumes an 8-bit control byte with active-low handshake lines.
package hsk_pkg;
    localparam int BIT_TREQ = 3;
    localparam int BIT_TACK = 4;
    localparam int BIT_TIP  = 5;
    localparam int BIT_DIR  = 4;
    localparam logic [7:0] CTL_RESET = 8'h38;

    typedef enum logic [1:0] {
        SEL_CTL   = 2'd0,
        SEL_MODE  = 2'd1,
        SEL_SHIFT = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/hsk_out_buf.sv
// Outbound packet collector: stores host bytes and presents a finished
// packet for one cycle. Assumes the caller never strobes capture when full
// and never captures and closes in the same cycle.
module hsk_out_buf #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_stb,
    input  logic [7:0]         cap_byte,
    input  logic               close_stb,
    output logic               full,
    output logic               pkt_valid,
    output logic [CW-1:0]      pkt_len,
    output logic [DEPTH*8-1:0] pkt_bytes
);
    logic [7:0]    mem [DEPTH];
    logic [CW-1:0] cnt_q;

    assign full = (cnt_q == CW'(DEPTH));

    // Count captured bytes and emit the packet on close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            pkt_valid <= 1'b0;
            pkt_len   <= '0;
        end else begin
            pkt_valid <= 1'b0;
            if (cap_stb && !full) begin
                cnt_q <= cnt_q + 1'b1;
            end else if (close_stb && cnt_q != '0) begin
                pkt_valid <= 1'b1;
                pkt_len   <= cnt_q;
                cnt_q     <= '0;
            end
        end
    end

    // Byte storage and flat view, one slot per generate step.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (cap_stb && !full && cnt_q == CW'(g))
                mem[g] <= cap_byte;
        end
        assign pkt_bytes[g*8 +: 8] = mem[g];
    end
endmodule

// File: rtl/hsk_reply_buf.sv
// Reply store with a read index. It reports the state the handshake sees in
// the current cycle: when a commit is present, that is the state after the
// commit. Assumes store writes are not made to bytes being committed in the
// same cycle.
module hsk_reply_buf #(
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          commit,
    input  logic [LW-1:0] commit_len,
    input  logic          fetch_stb,
    output logic          pend,
    output logic          last,
    output logic [7:0]    next_byte
);
    logic [7:0]    mem [DEPTH];
    logic [LW-1:0] size_q, idx_q;
    logic [LW-1:0] size_eff, idx_eff, len_clamp;

    // Select the state as seen after any commit in this cycle.
    always_comb begin
        len_clamp = (commit_len > LW'(DEPTH)) ? LW'(DEPTH) : commit_len;
        size_eff  = commit ? len_clamp : size_q;
        idx_eff   = commit ? '0 : idx_q;
        pend      = idx_eff < size_eff;
        last      = ({1'b0, idx_eff} + 1'b1) >= {1'b0, size_eff};
        next_byte = mem[idx_eff[AW-1:0]];
    end

    // Track the packet size and the read position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= '0;
            idx_q  <= '0;
        end else begin
            size_q <= size_eff;
            idx_q  <= idx_eff + LW'(fetch_stb);
        end
    end

    // Reply byte storage.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
    end
endmodule

// File: rtl/hsk_xfer_engine.sv
// Three-wire handshake byte transfer engine. Evaluates the TIP/TACK/TREQ
// handshake on every control write, mode write and reply commit, comparing
// against the TIP/TACK levels seen at the previous evaluation.
// Assumes one register write per cycle.
module hsk_xfer_engine
    import hsk_pkg::*;
#(
    parameter int OUT_DEPTH = 16,
    parameter int RPL_DEPTH = 128,
    localparam int OLW = $clog2(OUT_DEPTH + 1),
    localparam int RAW = $clog2(RPL_DEPTH),
    localparam int RLW = $clog2(RPL_DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [1:0]             reg_sel,
    input  logic [7:0]             reg_wdata,
    input  logic                   flag_clr,
    input  logic                   rpl_wr,
    input  logic [RAW-1:0]         rpl_waddr,
    input  logic [7:0]             rpl_wdata,
    input  logic                   rpl_commit,
    input  logic [RLW-1:0]         rpl_len,
    output logic [7:0]             port_b,
    output logic [7:0]             shift_data,
    output logic                   sh_flag,
    output logic                   pkt_valid,
    output logic [OLW-1:0]         pkt_len,
    output logic [OUT_DEPTH*8-1:0] pkt_bytes
);
    logic [7:0] b_q, b_new;
    logic [1:0] last_q;
    logic       dir_q, dir_new;
    logic [7:0] sr_q;
    logic       flag_q;
    logic       wr_ctl, wr_mode, wr_sh, eval;
    logic       tip, tack, pair_chg;
    logic       cap, fetch, close, set_flag, treq_nx;
    logic       out_full, rp_pend, rp_last;
    logic [7:0] rp_byte;

    // Decode the register write and form the control byte as updated.
    always_comb begin
        wr_ctl   = reg_wr && (reg_sel == SEL_CTL);
        wr_mode  = reg_wr && (reg_sel == SEL_MODE);
        wr_sh    = reg_wr && (reg_sel == SEL_SHIFT);
        eval     = wr_ctl || wr_mode || rpl_commit;
        b_new    = wr_ctl ? {reg_wdata[7:4], b_q[BIT_TREQ], reg_wdata[2:0]} : b_q;
        dir_new  = wr_mode ? reg_wdata[BIT_DIR] : dir_q;
        tip      = b_new[BIT_TIP];
        tack     = b_new[BIT_TACK];
        pair_chg = {tip, tack} != last_q;
    end

    // Handshake decision: choose the byte action, the TREQ level and the flag set.
    always_comb begin
        cap      = 1'b0;
        fetch    = 1'b0;
        close    = 1'b0;
        set_flag = rpl_commit;
        treq_nx  = b_q[BIT_TREQ];
        if (eval) begin
            if (!tip) begin
                if (dir_new) begin
                    if (pair_chg && !out_full) begin
                        cap      = 1'b1;
                        set_flag = 1'b1;
                    end
                end else if (rp_pend && pair_chg) begin
                    fetch    = 1'b1;
                    set_flag = 1'b1;
                    if (rp_last)
                        treq_nx = 1'b1;
                end
            end else if (last_q[1] && (tack != last_q[0])) begin
                treq_nx  = tack;
                set_flag = 1'b1;
            end else begin
                if (!last_q[1]) begin
                    close    = 1'b1;
                    set_flag = 1'b1;
                end
                if (rp_pend)
                    treq_nx = 1'b0;
            end
        end
    end

    // Register the control byte, the previous levels and the direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q    <= CTL_RESET;
            last_q <= 2'b11;
            dir_q  <= 1'b0;
        end else begin
            b_q   <= {b_new[7:4], treq_nx, b_new[2:0]};
            dir_q <= dir_new;
            if (eval)
                last_q <= {tip, tack};
        end
    end

    // Shift data register: a fetched reply byte or a host write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr_q <= '0;
        else if (fetch)
            sr_q <= rp_byte;
        else if (wr_sh)
            sr_q <= reg_wdata;
    end

    // Sticky shift flag: a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set_flag)
            flag_q <= 1'b1;
        else if (flag_clr)
            flag_q <= 1'b0;
    end

    hsk_out_buf #(.DEPTH(OUT_DEPTH)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_stb   (cap),
        .cap_byte  (sr_q),
        .close_stb (close),
        .full      (out_full),
        .pkt_valid (pkt_valid),
        .pkt_len   (pkt_len),
        .pkt_bytes (pkt_bytes)
    );

    hsk_reply_buf #(.DEPTH(RPL_DEPTH)) u_rpl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (rpl_wr),
        .wr_addr    (rpl_waddr),
        .wr_data    (rpl_wdata),
        .commit     (rpl_commit),
        .commit_len (rpl_len),
        .fetch_stb  (fetch),
        .pend       (rp_pend),
        .last       (rp_last),
        .next_byte  (rp_byte)
    );

    assign port_b     = b_q;
    assign shift_data = sr_q;
    assign sh_flag    = flag_q;
endmodule

// File: rtl/hsk_xfer_chk.sv
// Property checker for the handshake engine, attached by bind.
// Assumes eval is the engine's handshake evaluation strobe.
module hsk_xfer_chk #(
    parameter int OUT_DEPTH = 16,
    localparam int OLW = $clog2(OUT_DEPTH + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           eval,
    input logic           treq,
    input logic           tip,
    input logic           sh_flag,
    input logic           pkt_valid,
    input logic [OLW-1:0] pkt_len
);
    AST_PKT_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (pkt_len != '0 && pkt_len <= OLW'(OUT_DEPTH))); // R4
    AST_PKT_TIP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> tip); // R5
    AST_PKT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> sh_flag); // R5
    AST_PKT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> !pkt_valid); // R5
    AST_TREQ_ON_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(treq) |-> $past(eval)); // R12
    AST_FLAG_ON_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sh_flag) |-> $past(eval)); // R12
endmodule

bind hsk_xfer_engine hsk_xfer_chk #(.OUT_DEPTH(OUT_DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .eval      (eval),
    .treq      (port_b[3]),
    .tip       (port_b[5]),
    .sh_flag   (sh_flag),
    .pkt_valid (pkt_valid),
    .pkt_len   (pkt_len)
);

// File: tb/hsk_xfer_engine_bench.sv
module hsk_xfer_engine_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [1:0]   reg_sel = '0;
    logic [7:0]   reg_wdata = '0;
    logic         flag_clr = 1'b0;
    logic         rpl_wr = 1'b0;
    logic [6:0]   rpl_waddr = '0;
    logic [7:0]   rpl_wdata = '0;
    logic         rpl_commit = 1'b0;
    logic [7:0]   rpl_len = '0;
    logic [7:0]   port_b, shift_data;
    logic         sh_flag, pkt_valid;
    logic [4:0]   pkt_len;
    logic [127:0] pkt_bytes;
    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    hsk_xfer_engine u_hsk_xfer_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .flag_clr(flag_clr), .rpl_wr(rpl_wr),
        .rpl_waddr(rpl_waddr), .rpl_wdata(rpl_wdata), .rpl_commit(rpl_commit),
        .rpl_len(rpl_len), .port_b(port_b), .shift_data(shift_data),
        .sh_flag(sh_flag), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
        .pkt_bytes(pkt_bytes)
    );

    // {sel[27:26], data[25:18], exp_b[17:10], exp_sr[9:2], exp_flag[1], exp_pv[0]}
    localparam logic [27:0] VEC [17] = '{
        {2'd1, 8'h10, 8'h38, 8'h00, 1'b0, 1'b0},  // R12 mode write, idle
        {2'd2, 8'hA1, 8'h38, 8'hA1, 1'b0, 1'b0},  // R12 shift write only
        {2'd0, 8'h18, 8'h18, 8'hA1, 1'b1, 1'b0},  // R3 TIP falls, capture
        {2'd2, 8'hB2, 8'h18, 8'hB2, 1'b0, 1'b0},
        {2'd0, 8'h00, 8'h08, 8'hB2, 1'b1, 1'b0},  // R3 TACK toggle
        {2'd2, 8'hC3, 8'h08, 8'hC3, 1'b0, 1'b0},
        {2'd0, 8'h10, 8'h18, 8'hC3, 1'b1, 1'b0},  // R3
        {2'd0, 8'h38, 8'h38, 8'hC3, 1'b1, 1'b1},  // R5 deliver
        {2'd0, 8'h30, 8'h38, 8'hC3, 1'b0, 1'b0},  // R2 bit 3 ignored
        {2'd0, 8'hB0, 8'hB8, 8'hC3, 1'b0, 1'b0},  // R2 upper bits stored
        {2'd0, 8'h38, 8'h38, 8'hC3, 1'b0, 1'b0},
        {2'd0, 8'h28, 8'h20, 8'hC3, 1'b1, 1'b0},  // R8 TREQ follows TACK low
        {2'd0, 8'h38, 8'h38, 8'hC3, 1'b1, 1'b0},  // R8 TREQ follows TACK high
        {2'd2, 8'h55, 8'h38, 8'h55, 1'b0, 1'b0},  // R12
        {2'd1, 8'h00, 8'h38, 8'h55, 1'b0, 1'b0},
        {2'd0, 8'h18, 8'h18, 8'h55, 1'b0, 1'b0},  // R6 nothing pending
        {2'd0, 8'h38, 8'h38, 8'h55, 1'b1, 1'b0}   // R5 empty transfer
    };

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic clr_flag();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic put_reply(input int addr, input logic [7:0] data);
        @(negedge clk);
        rpl_wr = 1'b1; rpl_waddr = 7'(addr); rpl_wdata = data;
        @(negedge clk);
        rpl_wr = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 port_b", port_b, 8'h38);
        chk("R1 shift", shift_data, 8'h00);
        chk("R1 flag", sh_flag, 1'b0);
        chk("R1 valid", pkt_valid, 1'b0);
        chk("R1 len", pkt_len, 5'd0);

        for (int i = 0; i < 17; i++) begin
            clr_flag();
            wr_reg(VEC[i][27:26], VEC[i][25:18]);
            chk($sformatf("vec%0d port_b", i), port_b, VEC[i][17:10]);
            chk($sformatf("vec%0d shift", i), shift_data, VEC[i][9:2]);
            chk($sformatf("vec%0d flag", i), sh_flag, VEC[i][1]);
            chk($sformatf("vec%0d valid", i), pkt_valid, VEC[i][0]);
        end
        chk("R5 len", pkt_len, 5'd3);
        chk("R5 bytes", pkt_bytes[23:0], 24'hC3B2A1);

        // R10 / R9: commit of three bytes pulls TREQ low
        put_reply(0, 8'h11); put_reply(1, 8'h22); put_reply(2, 8'h33);
        clr_flag();
        @(negedge clk); rpl_commit = 1'b1; rpl_len = 8'd3;
        @(negedge clk); rpl_commit = 1'b0;
        chk("R10 flag", sh_flag, 1'b1);
        chk("R9 treq low", port_b, 8'h30);
        clr_flag();
        wr_reg(2'd0, 8'h18);
        chk("R6 byte0", shift_data, 8'h11);
        chk("R6 flag", sh_flag, 1'b1);
        chk("R6 treq held", port_b, 8'h10);
        wr_reg(2'd0, 8'h00);
        chk("R6 byte1", shift_data, 8'h22);
        wr_reg(2'd0, 8'h10);
        chk("R6 byte2", shift_data, 8'h33);
        chk("R7 treq high", port_b, 8'h18);
        clr_flag();
        wr_reg(2'd0, 8'h00);
        chk("R6 no more", shift_data, 8'h33);
        chk("R6 no flag", sh_flag, 1'b0);
        wr_reg(2'd0, 8'h38);
        chk("R5 end flag", sh_flag, 1'b1);
        chk("R5 end no pkt", pkt_valid, 1'b0);
        chk("R9 no pend", port_b, 8'h38);

        // R4: capture limit
        wr_reg(2'd1, 8'h10);
        for (int i = 0; i < 20; i++) begin
            wr_reg(2'd2, 8'h40 + 8'(i));
            clr_flag();
            wr_reg(2'd0, (i == 0) ? 8'h18 : ((i % 2 == 1) ? 8'h00 : 8'h10));
            chk($sformatf("R4 flag step%0d", i), sh_flag, (i < 16) ? 1'b1 : 1'b0);
        end
        wr_reg(2'd0, 8'h38);
        chk("R4 valid", pkt_valid, 1'b1);
        chk("R4 len", pkt_len, 5'd16);
        for (int k = 0; k < 16; k++)
            chk($sformatf("R4 byte%0d", k), pkt_bytes[k*8 +: 8], 8'h40 + 8'(k));

        // R11: clear alone, then set against clear
        clr_flag();
        chk("R11 clear", sh_flag, 1'b0);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 8'h28; flag_clr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; flag_clr = 1'b0;
        chk("R11 set wins", sh_flag, 1'b1);
        chk("R8 treq low", port_b, 8'h20);
        wr_reg(2'd0, 8'h38);

        // R13: commit together with TIP fall in receive direction
        wr_reg(2'd1, 8'h00);
        put_reply(0, 8'h77);
        clr_flag();
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 8'h18;
        rpl_commit = 1'b1; rpl_len = 8'd1;
        @(negedge clk);
        reg_wr = 1'b0; rpl_commit = 1'b0;
        chk("R13 byte", shift_data, 8'h77);
        chk("R13 treq", port_b, 8'h18);
        chk("R13 flag", sh_flag, 1'b1);
        wr_reg(2'd0, 8'h38);

        // R10: empty commit still flags, TREQ stays high
        clr_flag();
        @(negedge clk); rpl_commit = 1'b1; rpl_len = 8'd0;
        @(negedge clk); rpl_commit = 1'b0;
        chk("R10 empty flag", sh_flag, 1'b1);
        chk("R10 empty treq", port_b, 8'h38);

        summary();
        $finish;
    end
endmodule